// File: doc/BRIEF.md
# Asynchronous-Bus DRAM Controller with Strobe-Ordered Refresh

This block sits between a 68000-style asynchronous processor bus and a card of DRAM modules. It watches the address strobe, the two byte-lane data strobes, the read/write line and address lines A23..A1. It samples all of them with a fast system clock. From these it produces one shared row strobe, an upper and a lower byte-lane column strobe, four active-low bank selects, a row/column multiplexed DRAM address, and enable and direction for the external data transceivers. Timing counts system-clock ticks from the edge that accepts a cycle. Every delay is a parameter in ticks, rounded up so that each minimum is met.

The card serves byte addresses 0x200000 to 0x9FFFFF as four 2 MB banks. A bus cycle into the low 2 MB region is never served by the card. Such a cycle is used as a refresh slot instead: all column strobes fall ahead of the row strobe, so the DRAMs refresh from their own internal row counter. No refresh timer or refresh counter exists. Data never passes through the block; it only steers the transceivers. For that reason the block has no valid/ready interface, and all of its pins are plain control pins.

Top module: `dramc_top`

## Requirements
- R1: Address bits A23..A21 choose the region at acceptance. A value k in 1..4 drives `bank_sel_n[k-1]` low and the other selects high. A value of 0 drives all four selects low (refresh). A value of 5..7 leaves all four high. The selects return high on the same edge as the row strobe.
- R2: A cycle is accepted on the first clock edge at which the synchronised address strobe (SYNC_STAGES flops) is seen low while the controller is idle. For a bank hit, `ras_n` falls RAS_DLY edges after acceptance.
- R3: For a bank hit, a byte-lane column strobe falls at the later of two edges: edge CAS_RD_DLY (read, `rd_wr_n`=1) or CAS_WR_DLY (write) after acceptance, and the first edge after that lane's data strobe (`uds_n` upper, `lds_n` lower) is seen low through the synchroniser. A lane whose strobe stays high never gets a column strobe.
- R4: The column strobes rise on the edge at which the synchronised address strobe is first seen high. `ras_n` rises one edge later.
- R5: For a refresh cycle, both column strobes fall REF_CAS_DLY edges after acceptance and `ras_n` falls REF_RAS_DLY edges after it, at least one clock later. The data strobes are ignored. All strobes are held until the address strobe rises and are then released as in R4.
- R6: `dram_addr` carries A20..A11 (row) from acceptance. From the edge one clock after `ras_n` falls, it carries A10..A1 (column).
- R7: `xcvr_oe_n` is low from acceptance until the edge that sees the address strobe high, and only for a bank hit. `xcvr_to_cpu` holds the latched `rd_wr_n` (1: card drives the bus).
- R8: After `ras_n` rises, the controller waits PRECHARGE clocks before it can accept a new cycle.
- R9: If the address strobe rises before the row-strobe edge is reached, no strobe falls for that cycle.
- R10: During and after reset all strobes, selects and the transceiver enable are high, `xcvr_to_cpu` is 0 and `dram_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| as_n | input | 1 | Bus address strobe, active low |
| uds_n | input | 1 | Upper byte data strobe, active low |
| lds_n | input | 1 | Lower byte data strobe, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 23 | Bus word address A23..A1 |
| ras_n | output | 1 | Shared row strobe |
| cas_hi_n | output | 1 | Upper byte-lane column strobe |
| cas_lo_n | output | 1 | Lower byte-lane column strobe |
| bank_sel_n | output | 4 | Active-low bank selects |
| dram_addr | output | MUX_W (10) | Multiplexed row/column address |
| xcvr_oe_n | output | 1 | Data transceiver enable, active low |
| xcvr_to_cpu | output | 1 | Transceiver direction, 1 = toward bus |

## Verification
Two functions can meet in one clock: the release of the previous cycle and the acceptance of the next one. The bench provokes this by starting a new address strobe one clock after the last one ended, so the new strobe arrives while the controller is still releasing strobes or precharging. The next cycle is a refresh, so the refresh ordering is tested under the same pressure. The second meeting is a late write data strobe against the column-strobe threshold. The bench sweeps the strobe lag across that threshold. A behavioural per-clock model compares every output in every cycle. Separate monitors measure the row-strobe high time and the lead of the column strobe in refresh.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_MEM  = 2'd1,
    K_RFSH = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ACT   = 2'd1,
    S_DRAIN = 2'd2,
    S_PRE   = 2'd3
  } seq_e;

  // Region 0 is the unserved low 2 MB (refresh slot), 1..4 are card banks.
  function automatic kind_e classify(input logic [2:0] region);
    if (region == 3'd0)      return K_RFSH;
    else if (region <= 3'd4) return K_MEM;
    else                     return K_NONE;
  endfunction

endpackage

// File: rtl/dramc_sync.sv
module dramc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '1;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int TW        = 4,
  parameter int PRECHARGE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_s,
  input  logic [2:0]    region,
  input  logic          rd_wr_n,
  output seq_e          st,
  output logic [TW-1:0] tick,
  output kind_e         kind,
  output logic          is_read,
  output logic          start,
  output kind_e         start_kind,
  output logic [1:0]    start_bank
);
  localparam int PW = (PRECHARGE < 2) ? 1 : $clog2(PRECHARGE);
  localparam logic [TW-1:0] TICK_SAT = '1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRECHARGE - 1);

  logic [PW-1:0] pcnt;

  assign start      = (st == S_IDLE) && !as_s;
  assign start_kind = classify(region);
  assign start_bank = 2'(region - 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tick    <= '0;
      kind    <= K_NONE;
      is_read <= 1'b0;
      pcnt    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st      <= S_ACT;
          tick    <= '0;
          kind    <= start_kind;
          is_read <= rd_wr_n;
        end
        S_ACT: begin
          if (tick != TICK_SAT) tick <= tick + 1'b1;
          if (as_s) st <= S_DRAIN;
        end
        S_DRAIN: begin
          st   <= S_PRE;
          pcnt <= '0;
        end
        default: begin
          if (pcnt == PRE_LAST) st <= S_IDLE;
          else                  pcnt <= pcnt + 1'b1;
        end
      endcase
    end
  end

  // R8: the wait state never jumps straight back into an active cycle
  assert_pre_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE) |=> (st == S_PRE || st == S_IDLE));
endmodule

// File: rtl/dramc_strobes.sv
module dramc_strobes
  import dramc_pkg::*;
#(
  parameter int TW          = 4,
  parameter int RAS_DLY     = 3,
  parameter int CAS_RD_DLY  = 5,
  parameter int CAS_WR_DLY  = 6,
  parameter int REF_CAS_DLY = 4,
  parameter int REF_RAS_DLY = 5,
  parameter int PRECHARGE   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_e          st,
  input  logic [TW-1:0] tick,
  input  kind_e         kind,
  input  logic          is_read,
  input  logic          start,
  input  kind_e         start_kind,
  input  logic [1:0]    start_bank,
  input  logic          rd_wr_n,
  input  logic          as_s,
  input  logic          uds_s,
  input  logic          lds_s,
  output logic          ras_n,
  output logic          cas_hi_n,
  output logic          cas_lo_n,
  output logic [3:0]    bank_sel_n,
  output logic          xcvr_oe_n,
  output logic          xcvr_to_cpu
);
  localparam logic [TW-1:0] T_RAS  = TW'(RAS_DLY - 1);
  localparam logic [TW-1:0] T_RCAS = TW'(REF_CAS_DLY - 1);
  localparam logic [TW-1:0] T_RRAS = TW'(REF_RAS_DLY - 1);
  localparam logic [TW-1:0] T_CRD  = TW'(CAS_RD_DLY - 1);
  localparam logic [TW-1:0] T_CWR  = TW'(CAS_WR_DLY - 1);

  logic [TW-1:0] ras_thr, cas_thr;
  logic          live, refr, ras_go, cas_base, cas_hi_go, cas_lo_go;

  assign live     = (kind != K_NONE);
  assign refr     = (kind == K_RFSH);
  assign ras_thr  = refr ? T_RRAS : T_RAS;
  assign cas_thr  = refr ? T_RCAS : (is_read ? T_CRD : T_CWR);
  // once the row strobe is low it stays low until the drain state
  assign ras_go   = live && ((!as_s && tick >= ras_thr) || !ras_n);
  assign cas_base = live && !as_s && (tick >= cas_thr) && (refr || !ras_n);
  assign cas_hi_go = cas_base && (refr || !uds_s);
  assign cas_lo_go = cas_base && (refr || !lds_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_n       <= 1'b1;
      cas_hi_n    <= 1'b1;
      cas_lo_n    <= 1'b1;
      bank_sel_n  <= 4'hF;
      xcvr_oe_n   <= 1'b1;
      xcvr_to_cpu <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          case (start_kind)
            K_MEM:   bank_sel_n <= ~(4'b0001 << start_bank);
            K_RFSH:  bank_sel_n <= 4'h0;
            default: bank_sel_n <= 4'hF;
          endcase
          xcvr_oe_n   <= (start_kind != K_MEM);
          xcvr_to_cpu <= rd_wr_n;
        end
        S_ACT: begin
          ras_n    <= ~ras_go;
          cas_hi_n <= ~cas_hi_go;
          cas_lo_n <= ~cas_lo_go;
          if (as_s) xcvr_oe_n <= 1'b1;
        end
        S_DRAIN: begin
          ras_n      <= 1'b1;
          cas_hi_n   <= 1'b1;
          cas_lo_n   <= 1'b1;
          bank_sel_n <= 4'hF;
        end
        default: ;
      endcase
    end
  end

  // row-strobe high-time monitor for the precharge check
  localparam int HW = $clog2(PRECHARGE + 2);
  localparam logic [HW-1:0] HI_SAT = '1;
  logic [HW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_run <= '0;
    else if (!ras_n) hi_run <= '0;
    else if (hi_run != HI_SAT) hi_run <= hi_run + 1'b1;
  end

  assert_precharge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_run >= HW'(PRECHARGE)));

  assert_release_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (cas_hi_n && cas_lo_n && $past(cas_hi_n) && $past(cas_lo_n)));

  assert_bank_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~bank_sel_n) <= 1) || (bank_sel_n == 4'h0));

  assert_no_xcvr_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel_n == 4'h0) |-> xcvr_oe_n);

  assert_cbr_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && bank_sel_n == 4'h0) |-> ($past(!cas_hi_n) && $past(!cas_lo_n)));

  assert_lane_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_hi_n) && bank_sel_n != 4'h0) |-> !$past(uds_s));
endmodule

// File: rtl/dramc_addr_mux.sv
module dramc_addr_mux
  import dramc_pkg::*;
#(
  parameter int TW      = 4,
  parameter int MUX_W   = 10,
  parameter int RAS_DLY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  seq_e             st,
  input  logic [TW-1:0]    tick,
  input  kind_e            kind,
  input  logic [23:1]      cpu_addr,
  output logic [MUX_W-1:0] dram_addr
);
  localparam int ROW_LO = MUX_W + 1;
  localparam int ROW_HI = 2 * MUX_W;
  localparam logic [TW-1:0] T_COL = TW'(RAS_DLY);

  logic [MUX_W-1:0] row_half, col_half;
  assign row_half = cpu_addr[ROW_HI:ROW_LO];
  assign col_half = cpu_addr[MUX_W:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        dram_addr <= '0;
    else if (start)                                    dram_addr <= row_half;
    else if (st == S_ACT && kind == K_MEM && tick == T_COL) dram_addr <= col_half;
  end

  assert_row_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACT && kind == K_MEM && tick != '0 && tick <= T_COL) |-> $stable(dram_addr));
endmodule

// File: rtl/dramc_top.sv
module dramc_top
  import dramc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAS_DLY     = 3,
  parameter int CAS_RD_DLY  = 5,
  parameter int CAS_WR_DLY  = 6,
  parameter int REF_CAS_DLY = 4,
  parameter int REF_RAS_DLY = 5,
  parameter int PRECHARGE   = 2,
  parameter int MUX_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             as_n,
  input  logic             uds_n,
  input  logic             lds_n,
  input  logic             rd_wr_n,
  input  logic [23:1]      cpu_addr,
  output logic             ras_n,
  output logic             cas_hi_n,
  output logic             cas_lo_n,
  output logic [3:0]       bank_sel_n,
  output logic [MUX_W-1:0] dram_addr,
  output logic             xcvr_oe_n,
  output logic             xcvr_to_cpu
);
  localparam int MAX_A = (CAS_WR_DLY > CAS_RD_DLY) ? CAS_WR_DLY : CAS_RD_DLY;
  localparam int MAX_B = (REF_RAS_DLY > MAX_A) ? REF_RAS_DLY : MAX_A;
  localparam int TW    = $clog2(MAX_B + 2);

  logic [2:0] strb_s;
  logic       as_s, uds_s, lds_s;

  dramc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({as_n, uds_n, lds_n}), .q(strb_s));
  assign {as_s, uds_s, lds_s} = strb_s;

  seq_e          st;
  logic [TW-1:0] tick;
  kind_e         kind, start_kind;
  logic          is_read, start;
  logic [1:0]    start_bank;

  dramc_seq #(.TW(TW), .PRECHARGE(PRECHARGE)) u_seq (
    .clk(clk), .rst_n(rst_n), .as_s(as_s), .region(cpu_addr[23:21]),
    .rd_wr_n(rd_wr_n), .st(st), .tick(tick), .kind(kind), .is_read(is_read),
    .start(start), .start_kind(start_kind), .start_bank(start_bank));

  dramc_strobes #(
    .TW(TW), .RAS_DLY(RAS_DLY), .CAS_RD_DLY(CAS_RD_DLY), .CAS_WR_DLY(CAS_WR_DLY),
    .REF_CAS_DLY(REF_CAS_DLY), .REF_RAS_DLY(REF_RAS_DLY), .PRECHARGE(PRECHARGE)
  ) u_strobes (
    .clk(clk), .rst_n(rst_n), .st(st), .tick(tick), .kind(kind), .is_read(is_read),
    .start(start), .start_kind(start_kind), .start_bank(start_bank),
    .rd_wr_n(rd_wr_n), .as_s(as_s), .uds_s(uds_s), .lds_s(lds_s),
    .ras_n(ras_n), .cas_hi_n(cas_hi_n), .cas_lo_n(cas_lo_n),
    .bank_sel_n(bank_sel_n), .xcvr_oe_n(xcvr_oe_n), .xcvr_to_cpu(xcvr_to_cpu));

  dramc_addr_mux #(.TW(TW), .MUX_W(MUX_W), .RAS_DLY(RAS_DLY)) u_mux (
    .clk(clk), .rst_n(rst_n), .start(start), .st(st), .tick(tick), .kind(kind),
    .cpu_addr(cpu_addr), .dram_addr(dram_addr));

  // R9: a strobe that ends before the row threshold leaves the row strobe idle
  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACT && as_s && ras_n) |=> ras_n);
endmodule

// File: tb/dramc_top_tb.sv
module dramc_top_tb;
  localparam int SYNC = 2, RAS = 3, CRD = 5, CWR = 6, RCAS = 4, RRAS = 5, PRE = 2, MW = 10;

  logic clk = 0, rst_n = 0;
  logic as_n = 1, uds_n = 1, lds_n = 1, rd_wr_n = 1;
  logic [23:1] cpu_addr = '0;
  logic ras_n, cas_hi_n, cas_lo_n, xcvr_oe_n, xcvr_to_cpu;
  logic [3:0] bank_sel_n;
  logic [MW-1:0] dram_addr;

  dramc_top u_dut (.clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .rd_wr_n(rd_wr_n), .cpu_addr(cpu_addr), .ras_n(ras_n), .cas_hi_n(cas_hi_n),
    .cas_lo_n(cas_lo_n), .bank_sel_n(bank_sel_n), .dram_addr(dram_addr),
    .xcvr_oe_n(xcvr_oe_n), .xcvr_to_cpu(xcvr_to_cpu));

  always #10 clk = ~clk;

  int vectors = 0, misses = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit as_q[$], u_q[$], l_q[$];
  int ms = 0, mt = 0, mp = 0, mkind = 0, mbank = 0;
  bit mrd = 0;
  bit e_ras = 1, e_cu = 1, e_cl = 1, e_oe = 1, e_dir = 0;
  bit [3:0] e_bank = 4'hF;
  bit [MW-1:0] e_addr = '0;
  bit sa, su, sl, row_low, cbase;
  int rthr, cthr;

  always @(posedge clk) begin
    if (!rst_n) begin
      as_q = {}; u_q = {}; l_q = {};
      for (int i = 0; i < SYNC; i++) begin as_q.push_back(1); u_q.push_back(1); l_q.push_back(1); end
      ms = 0; mt = 0; mp = 0; mkind = 0;
      e_ras = 1; e_cu = 1; e_cl = 1; e_oe = 1; e_dir = 0; e_bank = 4'hF; e_addr = '0;
    end else begin
      sa = as_q[SYNC-1]; su = u_q[SYNC-1]; sl = l_q[SYNC-1];
      case (ms)
        0: if (!sa) begin
          mkind = (cpu_addr[23:21] == 0) ? 2 : (cpu_addr[23:21] <= 4 ? 1 : 0);
          mbank = int'(cpu_addr[23:21]) - 1;
          e_bank = (mkind == 1) ? ~(4'b1 << mbank) : (mkind == 2 ? 4'h0 : 4'hF);
          e_oe = (mkind != 1); e_dir = rd_wr_n; mrd = rd_wr_n;
          e_addr = cpu_addr[2*MW:MW+1];
          ms = 1; mt = 0;
        end
        1: begin
          rthr = (mkind == 2) ? RRAS : RAS;
          cthr = (mkind == 2) ? RCAS : (mrd ? CRD : CWR);
          row_low = !e_ras;
          cbase = (mkind != 0) && !sa && (mt + 1 >= cthr) && (mkind == 2 || row_low);
          e_cu = !(cbase && (mkind == 2 || !su));
          e_cl = !(cbase && (mkind == 2 || !sl));
          e_ras = !((mkind != 0) && ((!sa && mt + 1 >= rthr) || row_low));
          if (mkind == 1 && mt == RAS) e_addr = cpu_addr[MW:1];
          if (sa) begin e_oe = 1; ms = 2; end
          if (mt < 1000) mt++;
        end
        2: begin e_ras = 1; e_cu = 1; e_cl = 1; e_bank = 4'hF; ms = 3; mp = 0; end
        default: if (mp == PRE - 1) ms = 0; else mp++;
      endcase
      void'(as_q.pop_back()); as_q.push_front(as_n);
      void'(u_q.pop_back());  u_q.push_front(uds_n);
      void'(l_q.pop_back());  l_q.push_front(lds_n);
    end
  end

  // ---------------- per-clock compare and monitors ----------------
  bit p_ras = 1, p_cu = 1;
  int ras_hi_run = 0, ref_cas_cyc = -1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk("R2", "ras_n", ras_n, e_ras);
      chk("R3", "cas_hi_n", cas_hi_n, e_cu);
      chk("R3", "cas_lo_n", cas_lo_n, e_cl);
      chk("R1", "bank_sel_n", bank_sel_n, e_bank);
      chk("R6", "dram_addr", dram_addr, e_addr);
      chk("R7", "xcvr_oe_n", xcvr_oe_n, e_oe);
      chk("R7", "xcvr_to_cpu", xcvr_to_cpu, e_dir);
      // R8: row strobe high time before each fall
      if (p_ras && !ras_n) chk("R8", "ras high run ok", ras_hi_run >= PRE, 1);
      ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
      // R5: column strobe leads row strobe in refresh
      if (bank_sel_n == 4'h0 && p_cu && !cas_hi_n) ref_cas_cyc = cyc;
      if (bank_sel_n == 4'h0 && p_ras && !ras_n)
        chk("R5", "refresh cas lead", (ref_cas_cyc >= 0) && (cyc - ref_cas_cyc >= 1), 1);
      p_ras = ras_n; p_cu = cas_hi_n;
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus_cyc(input logic [23:0] a, input bit rd, input bit u, input bit l,
                         input int ds_lag, input int hold, input int gap);
    @(negedge clk);
    cpu_addr = a[23:1]; rd_wr_n = rd; as_n = 0;
    if (ds_lag == 0) begin uds_n = !u; lds_n = !l; end
    for (int i = 0; i < ds_lag; i++) @(negedge clk);
    if (ds_lag != 0) begin uds_n = !u; lds_n = !l; end
    for (int i = 0; i < hold; i++) @(negedge clk);
    as_n = 1; uds_n = 1; lds_n = 1;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "reset strobes", {ras_n, cas_hi_n, cas_lo_n, xcvr_oe_n}, 4'hF);
    chk("R10", "reset selects", bank_sel_n, 4'hF);
    chk("R10", "reset addr/dir", {dram_addr, xcvr_to_cpu}, 0);
    rst_n = 1;
    bus_cyc(24'h2_3A5_6C, 1, 1, 1, 0, 10, 6);   // R2 R3 word read bank 0
    bus_cyc(24'h4_1F0_02, 0, 1, 0, 1, 10, 6);   // R3 upper byte write, early strobe
    bus_cyc(24'h6_0AB_CE, 0, 1, 1, 5, 10, 6);   // R3 late write strobes past threshold
    bus_cyc(24'h8_FFF_FE, 1, 0, 1, 0, 10, 6);   // R3 lower byte read bank 3
    bus_cyc(24'h1_234_56, 1, 1, 1, 0, 10, 6);   // R5 refresh slot
    bus_cyc(24'hA_000_00, 1, 1, 1, 0, 10, 6);   // R9/R1 unmapped region
    bus_cyc(24'hE_123_40, 0, 1, 1, 0, 10, 6);   // R1 unmapped, write
    bus_cyc(24'h3_000_10, 1, 1, 1, 0, 1, 6);    // R9 aborted bank cycle
    bus_cyc(24'h5_555_54, 1, 1, 1, 0, 8, 0);    // R4 R8 back-to-back into refresh
    bus_cyc(24'h0_000_20, 1, 1, 1, 0, 8, 0);
    bus_cyc(24'h7_ABC_DE, 0, 1, 1, 3, 8, 0);    // R8 refresh into write
    for (int lag = 0; lag < 7; lag++) bus_cyc(24'h9_876_54, 0, 1, 1, lag, 9, 4); // R3 sweep
    repeat (10) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++; misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule